// File: doc/BRIEF.md
# Permuted Pseudo-Random Interleaver Index Generator

This block produces the write or read order for a pseudo-random symbol interleaver. A linear feedback shift register advances by one state per cycle. Each state goes through a programmable bit shuffle, and one is subtracted from the result to form a candidate symbol index. Candidates at or above a block-size limit are thrown away. Each surviving symbol index is then spread into a run of consecutive soft-bit indices, one for each bit that the modulation carries.

Software loads the feedback taps, the feedback style, the shuffle map, the limit, the bits per symbol, the seed and the number of symbols to produce, then pulses `start`. Indices leave one per cycle on a valid/ready port. Rejected candidates cost a cycle and produce nothing, so the output has gaps. When the programmed number of symbols has been fully emitted, `done` pulses and the block returns to idle.

Top module: `lfsr_perm_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `cfg_err` and `out_valid` are all low.
- R2: A start accepted from idle loads the register with `cfg_seed`. Each following step sets the next state as follows. With `cfg_galois`=0, the state shifts up by one and the new bit 0 is the XOR of the state bits selected by `cfg_taps`. With `cfg_galois`=1, the state shifts up by one with a 0 entering bit 0, and if the old top bit was 1 the result is XORed with `cfg_taps`. The register steps once per cycle while candidates are rejected, and holds while an accepted symbol waits for the output stage.
- R3: Bit j of the shuffled word equals state bit m, where m is the field `cfg_perm[j*SEL_W +: SEL_W]`. A field value of W or more makes bit j read as 0.
- R4: The candidate is the shuffled word minus one, modulo 2^W. It is accepted only when it is below `cfg_limit`. A rejected candidate produces no output.
- R5: An accepted symbol s with b bits per symbol produces exactly the b indices s*b+0, s*b+1, ..., s*b+b-1, in that order.
- R6: Symbols are emitted in the order in which their register states occur.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_index` stay unchanged.
- R8: After `cfg_count` accepted symbols have been fully emitted, `done` is high for exactly one cycle and `busy` falls in that same cycle. With `cfg_count`=0, `done` pulses and no index is emitted.
- R9: A start from idle with `cfg_seed`=0, or with `cfg_bps` outside 2..6, raises `cfg_err` for one cycle. In that case `busy` stays low and neither an index nor `done` follows.
- R10: A start while busy is ignored. The configuration captured at the accepted start stays in force until `done`.
- R11: With maximal-length taps and `cfg_count` equal to `cfg_limit`, the emitted symbols are each value 0..`cfg_limit`-1 exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a job when idle |
| cfg_taps | input | W | Feedback tap mask |
| cfg_galois | input | 1 | 0: shift-register feedback, 1: distributed feedback |
| cfg_perm | input | W*SEL_W | Bit shuffle map, one SEL_W field per output bit |
| cfg_limit | input | W | Block size; candidates at or above it are dropped |
| cfg_bps | input | 3 | Soft bits per symbol, 2..6 |
| cfg_seed | input | W | Initial register state, nonzero |
| cfg_count | input | CNT_W | Number of symbols to accept |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| cfg_err | output | 1 | One-cycle pulse for a rejected start |
| out_valid | output | 1 | `out_index` holds a soft-bit index |
| out_ready | input | 1 | Downstream accepts the index |
| out_index | output | W+3 | Soft-bit index |

## Verification
The assertions assume that reset is applied before the first start, and that `cfg_count` never exceeds the number of states that pass the filter in one register period. Otherwise a job would never finish. The bench meets both by using maximal-length tap masks and keeping each count at or below the limit. The range assertion also assumes a nonzero seed, so that the shuffled word is never zero. The bench keeps within this by starting jobs only through the checked start path, where a zero seed is refused.

// File: rtl/lpag_pkg.sv
package lpag_pkg;
  localparam int BPS_W   = 3;
  localparam int MIN_BPS = 2;
  localparam int MAX_BPS = 6;

  typedef enum logic {
    FB_SHIFT = 1'b0,
    FB_SPREAD = 1'b1
  } fb_mode_t;
endpackage

// File: rtl/lpag_lfsr.sv
module lpag_lfsr
  import lpag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  input  fb_mode_t     mode,
  input  logic [W-1:0] taps,
  output logic [W-1:0] state
);

  logic [W-1:0] shift_next;
  logic [W-1:0] spread_next;

  always_comb begin
    shift_next  = {state[W-2:0], ^(state & taps)};
    spread_next = {state[W-2:0], 1'b0} ^ (taps & {W{state[W-1]}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= {{(W-1){1'b0}}, 1'b1};
    end else if (load) begin
      state <= seed;
    end else if (step) begin
      state <= (mode == FB_SPREAD) ? spread_next : shift_next;
    end
  end

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed)); // R2
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(state)); // R2

endmodule

// File: rtl/lpag_bitperm.sv
module lpag_bitperm #(
  parameter int W     = 16,
  parameter int SEL_W = 4
) (
  input  logic [W-1:0]       din,
  input  logic [W*SEL_W-1:0] map,
  output logic [W-1:0]       dout
);

  for (genvar j = 0; j < W; j++) begin : g_bit
    logic [SEL_W-1:0] sel;
    assign sel = map[j*SEL_W +: SEL_W];
    always_comb begin
      dout[j] = 1'b0;
      for (int i = 0; i < W; i++) begin
        if (sel == SEL_W'(i)) dout[j] = din[i];
      end
    end
  end

endmodule

// File: rtl/lpag_expand.sv
module lpag_expand
  import lpag_pkg::*;
#(
  parameter int W     = 16,
  parameter int OUT_W = W + BPS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     sym,
  input  logic [BPS_W-1:0] bps,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_index,
  output logic             free
);

  logic [BPS_W-1:0] beat;
  logic             last;

  assign last = (beat == bps - BPS_W'(1));
  assign free = !out_valid || (out_ready && last);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_index <= '0;
      beat      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_index <= OUT_W'(sym) * OUT_W'(bps);
      beat      <= '0;
    end else if (out_valid && out_ready) begin
      if (last) begin
        out_valid <= 1'b0;
      end else begin
        out_index <= out_index + OUT_W'(1);
        beat      <= beat + BPS_W'(1);
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index))); // R7
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !last) |=> (out_valid && out_index == $past(out_index) + OUT_W'(1))); // R5
  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (rst)
    load |-> free); // R6

endmodule

// File: rtl/lfsr_perm_addr_gen.sv
module lfsr_perm_addr_gen
  import lpag_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 16,
  localparam int SEL_W = $clog2(W),
  localparam int OUT_W = W + BPS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [W-1:0]       cfg_taps,
  input  logic               cfg_galois,
  input  logic [W*SEL_W-1:0] cfg_perm,
  input  logic [W-1:0]       cfg_limit,
  input  logic [BPS_W-1:0]   cfg_bps,
  input  logic [W-1:0]       cfg_seed,
  input  logic [CNT_W-1:0]   cfg_count,
  output logic               busy,
  output logic               done,
  output logic               cfg_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_index
);

  logic [W-1:0]       taps_q;
  fb_mode_t           mode_q;
  logic [W*SEL_W-1:0] perm_q;
  logic [W-1:0]       limit_q;
  logic [BPS_W-1:0]   bps_q;
  logic [CNT_W-1:0]   count_q;
  logic [CNT_W-1:0]   acc_cnt;

  logic [W-1:0] state;
  logic [W-1:0] shuffled;
  logic [W-1:0] cand;
  logic         hit;
  logic         more;
  logic         exp_free;
  logic         accept;
  logic         step;
  logic         bad_cfg;
  logic         go;

  assign bad_cfg = (cfg_seed == '0) ||
                   (cfg_bps < BPS_W'(MIN_BPS)) ||
                   (cfg_bps > BPS_W'(MAX_BPS));
  assign go     = start && !busy && !bad_cfg;
  assign cand   = shuffled - W'(1);
  assign hit    = cand < limit_q;
  assign more   = acc_cnt != count_q;
  assign accept = busy && more && hit && exp_free;
  assign step   = busy && more && (!hit || exp_free);

  lpag_lfsr #(.W(W)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .load (go),
    .seed (cfg_seed),
    .step (step),
    .mode (mode_q),
    .taps (taps_q),
    .state(state)
  );

  lpag_bitperm #(.W(W), .SEL_W(SEL_W)) u_perm (
    .din (state),
    .map (perm_q),
    .dout(shuffled)
  );

  lpag_expand #(.W(W), .OUT_W(OUT_W)) u_expand (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .sym      (cand),
    .bps      (bps_q),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_index(out_index),
    .free     (exp_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
      acc_cnt <= '0;
      taps_q  <= '0;
      mode_q  <= FB_SHIFT;
      perm_q  <= '0;
      limit_q <= '0;
      bps_q   <= BPS_W'(MIN_BPS);
      count_q <= '0;
    end else begin
      done    <= 1'b0;
      cfg_err <= 1'b0;
      if (!busy) begin
        if (start && bad_cfg) begin
          cfg_err <= 1'b1;
        end else if (go) begin
          busy    <= 1'b1;
          acc_cnt <= '0;
          taps_q  <= cfg_taps;
          mode_q  <= fb_mode_t'(cfg_galois);
          perm_q  <= cfg_perm;
          limit_q <= cfg_limit;
          bps_q   <= cfg_bps;
          count_q <= cfg_count;
        end
      end else begin
        if (accept) acc_cnt <= acc_cnt + CNT_W'(1);
        if (!more && !out_valid) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !out_valid)); // R8
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!busy && !out_valid)); // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_index < OUT_W'(limit_q) * OUT_W'(bps_q))); // R4
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !cfg_err); // R10

endmodule

// File: tb/lfsr_perm_addr_gen_bench.sv
module lfsr_perm_addr_gen_bench;
  localparam int W   = 10;
  localparam int CNT = 16;
  localparam int SEL = 4;
  localparam int OW  = W + 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   cfg_taps = '0;
  logic           cfg_galois = 1'b0;
  logic [W*SEL-1:0] cfg_perm = '0;
  logic [W-1:0]   cfg_limit = '0;
  logic [2:0]     cfg_bps = 3'd2;
  logic [W-1:0]   cfg_seed = 10'd1;
  logic [CNT-1:0] cfg_count = '0;
  logic           busy, done, cfg_err, out_valid;
  logic           out_ready = 1'b1;
  logic [OW-1:0]  out_index;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rmode = 0;
  int cur_bps = 2;
  logic [OW-1:0] exp_q[$];
  int seen[1024];
  logic prev_stall = 1'b0;
  logic [OW-1:0] prev_idx = '0;

  always #2ns clk = ~clk;

  lfsr_perm_addr_gen #(.W(W), .CNT_W(CNT)) u_lfsr_perm_addr_gen (
    .clk(clk), .rst(rst), .start(start), .cfg_taps(cfg_taps),
    .cfg_galois(cfg_galois), .cfg_perm(cfg_perm), .cfg_limit(cfg_limit),
    .cfg_bps(cfg_bps), .cfg_seed(cfg_seed), .cfg_count(cfg_count),
    .busy(busy), .done(done), .cfg_err(cfg_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_index(out_index)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] m_shuffle(logic [W-1:0] s, logic [W*SEL-1:0] mp);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) begin
      int f;
      f = int'(mp[j*SEL +: SEL]);
      r[j] = (f < W) ? s[f] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] m_next(logic [W-1:0] s, logic [W-1:0] t, logic gal);
    logic [W-1:0] r;
    if (gal) begin
      r = s << 1;
      if (s[W-1]) r = r ^ t;
    end else begin
      r = {s[W-2:0], ^(s & t)};
    end
    return r;
  endfunction

  function automatic logic [W*SEL-1:0] build_map(int kind);
    logic [W*SEL-1:0] m;
    for (int j = 0; j < W; j++) begin
      case (kind)
        0: m[j*SEL +: SEL] = SEL'(W - 1 - j);
        1: m[j*SEL +: SEL] = SEL'((j + 3) % W);
        default: m[j*SEL +: SEL] = (j == 0) ? SEL'(15) : SEL'(j);
      endcase
    end
    return m;
  endfunction

  // driver: model fills the scoreboard, then the job is started
  task automatic run_job(input logic [W-1:0] taps, input logic gal, input logic [W*SEL-1:0] mp,
                         input int limit, input int bps, input logic [W-1:0] seed, input int count);
    logic [W-1:0] st;
    int acc;
    st = seed;
    acc = 0;
    check(exp_q.size() == 0, "R8 queue empty before job", exp_q.size(), 0);
    while (acc < count) begin
      logic [W-1:0] c;
      c = m_shuffle(st, mp) - W'(1);
      if (int'(c) < limit) begin
        for (int k = 0; k < bps; k++) exp_q.push_back(OW'(int'(c) * bps + k));
        acc++;
      end
      st = m_next(st, taps, gal);
    end
    for (int i = 0; i < 1024; i++) seen[i] = 0;
    cur_bps = bps;
    @(posedge clk); #1;
    cfg_taps = taps; cfg_galois = gal; cfg_perm = mp; cfg_limit = W'(limit);
    cfg_bps = 3'(bps); cfg_seed = seed; cfg_count = CNT'(count);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit got;
    got = 1'b0;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
    check(got, {"R8 done seen ", tag}, int'(got), 1);
    check(!busy, {"R8 busy low with done ", tag}, int'(busy), 0);
    check(exp_q.size() == 0, {"R5 R6 all indices emitted ", tag}, exp_q.size(), 0);
    @(negedge clk);
    check(!done, {"R8 done one cycle ", tag}, int'(done), 0);
  endtask

  task automatic err_job(input logic [W-1:0] seed, input int bps, input string tag);
    @(posedge clk); #1;
    cfg_seed = seed; cfg_bps = 3'(bps); cfg_count = CNT'(5); cfg_limit = W'(100);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(cfg_err, {"R9 cfg_err raised ", tag}, int'(cfg_err), 1);
    check(!busy, {"R9 busy stays low ", tag}, int'(busy), 0);
    @(negedge clk);
    check(!cfg_err, {"R9 cfg_err one cycle ", tag}, int'(cfg_err), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!out_valid && !done && !busy, {"R9 nothing follows ", tag},
            int'({out_valid, done, busy}), 0);
    end
  endtask

  // ready pattern and watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    #1;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = (cyc % 7) < 3;
    endcase
  end

  // monitor: pops the scoreboard on each transfer
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check(out_valid && out_index == prev_idx, "R7 stalled output held",
              int'(out_index), int'(prev_idx));
      end
      prev_stall = out_valid && !out_ready;
      prev_idx   = out_index;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected index", int'(out_index), -1);
        end else begin
          logic [OW-1:0] e;
          e = exp_q.pop_front();
          check(out_index == e, "R5 R6 index order", int'(out_index), int'(e));
        end
        if (int'(out_index) % cur_bps == 0 && int'(out_index) / cur_bps < 1024)
          seen[int'(out_index) / cur_bps]++;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !cfg_err && !out_valid, "R1 reset state",
          int'({busy, done, cfg_err, out_valid}), 0);

    // R2 R3 R4 R11: shift feedback, bit reversal, full block
    rmode = 0;
    run_job(10'h240, 1'b0, build_map(0), 700, 2, 10'h155, 700);
    wait_done("job A");
    begin
      int bad;
      bad = 0;
      for (int s = 0; s < 700; s++) if (seen[s] != 1) bad++;
      check(bad == 0, "R11 every symbol once", bad, 0);
    end

    // R2 spread feedback, rotate map, 6 bits, stalls, stray start (R10)
    rmode = 1;
    run_job(10'h081, 1'b1, build_map(1), 300, 6, 10'h0a3, 120);
    repeat (20) @(posedge clk);
    #1 cfg_seed = 10'd5; cfg_bps = 3'd3; cfg_limit = 10'd20; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_done("job B R10");

    // R3 out-of-range map entry reads 0, 3 bits, heavy stalls
    rmode = 2;
    run_job(10'h240, 1'b0, build_map(2), 500, 3, 10'h3ff, 60);
    wait_done("job C R3");

    // R2 R5 4 bits with spread feedback
    rmode = 1;
    run_job(10'h081, 1'b1, build_map(0), 1000, 4, 10'h001, 40);
    wait_done("job D");

    // R8 zero count
    rmode = 0;
    run_job(10'h240, 1'b0, build_map(0), 100, 2, 10'h011, 0);
    wait_done("job E zero count");

    // R9 refused starts
    err_job(10'h000, 2, "zero seed");
    err_job(10'h012, 7, "bps 7");
    err_job(10'h012, 1, "bps 1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule